// File: doc/BRIEF.md
# Monotonic Tamper-Detecting Counter

This block keeps a metering count that may only grow. Each cycle in which an update is offered, a signed increment is checked and, if it passes, added to the stored value. Two checks guard every update: the increment must not be negative, and the new total must not be smaller than the old one, which catches a sum that wraps past the top of the counter. An update that fails either check is thrown away. The stored value stays as it was, a saturating anomaly tally advances, a one-cycle anomaly event is flagged and the tamper output is raised.

A configuration input selects whether a failure is fatal. With locking enabled, the first failure moves the block into a locked state. In that state every later update is ignored and tamper stays high until the next asynchronous power-on reset. There is no synchronous clear. Only the power-on reset returns the value to zero, so nothing reachable through the update interface can lower the count.

Top module: `mono_counter`

## Requirements
- R1: After the asynchronous reset (active-low `rst_n`), `count_o` and `anomaly_cnt_o` are zero and `anomaly_o`, `tamper_o` and `locked_o` are low.
- R2: A valid increment with bit INC_W-1 clear, whose sum does not exceed 2^CNT_W-1, is added to `count_o`, and the new value is visible one clock after the update edge.
- R3: An update whose sum would wrap, meaning the new value would be below the current one, is rejected and `count_o` is unchanged.
- R4: An increment with bit INC_W-1 set (negative in two's complement) is rejected and `count_o` is unchanged.
- R5: While `inc_valid` is low, `count_o` does not change.
- R6: Each rejected update raises `anomaly_cnt_o` by one, and it saturates at 2^ANOM_W-1.
- R7: A rejected update raises `anomaly_o` for exactly one cycle and raises `tamper_o` in that same cycle.
- R8: If `lock_en` is high in the cycle of a rejection, `locked_o` and `tamper_o` go high and stay high until reset.
- R9: While locked, all updates are ignored. `count_o` and `anomaly_cnt_o` stay frozen and `anomaly_o` stays low.
- R10: If `lock_en` is low at a rejection, `tamper_o` falls again in the next cycle unless a new rejection occurs, and later valid updates are accepted.
- R11: A zero increment is accepted. It leaves `count_o` unchanged and raises no anomaly.
- R12: `count_o` never decreases from one cycle to the next outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| inc_valid | input | 1 | An update is offered this cycle |
| inc_value | input | INC_W | Signed two's-complement increment |
| lock_en | input | 1 | Lock on the first rejected update |
| count_o | output | CNT_W | Stored count |
| anomaly_cnt_o | output | ANOM_W | Saturating tally of rejected updates |
| anomaly_o | output | 1 | One-cycle flag for a rejected update |
| tamper_o | output | 1 | Tamper response |
| locked_o | output | 1 | Block is locked until reset |

## Verification
A wrong verdict from the check logic shows up one clock after the offending update. Either `count_o` takes a value that has wrapped or gone down, or `anomaly_cnt_o` and `anomaly_o` fail to move together. A fault in the guard state is subtler, because it only becomes visible on the next offered update: a block that should be locked would then accept the update or raise a fresh anomaly flag, or tamper would drop. The bench therefore follows every lock with several ignored updates. It uses a narrow counter so that wrap-around and tally saturation are reached within a few dozen cycles.

// File: rtl/mono_pkg.sv
package mono_pkg;

   typedef enum logic [0:0] {
      GS_RUN    = 1'b0,
      GS_LOCKED = 1'b1
   } guard_state_e;

   typedef struct packed {
      logic accept;
      logic reject;
   } verdict_t;

endpackage

// File: rtl/mono_check.sv
module mono_check #(
   parameter int CNT_W = 64,
   parameter int INC_W = 16
) (
   input  logic [CNT_W-1:0]  cur,
   input  logic              valid,
   input  logic [INC_W-1:0]  inc,
   output mono_pkg::verdict_t verdict,
   output logic [CNT_W-1:0]  nxt
);
   localparam int PAD_W = CNT_W - INC_W;

   logic [CNT_W-1:0] inc_ext;
   logic             is_neg;
   logic             is_wrap;

   generate
      if (PAD_W > 0) begin : g_pad
         assign inc_ext = {{PAD_W{1'b0}}, inc};
      end else begin : g_nopad
         assign inc_ext = inc;
      end
   endgenerate

   assign is_neg  = inc[INC_W-1];
   assign nxt     = cur + inc_ext;
   assign is_wrap = (nxt < cur);

   always_comb begin
      verdict.accept = valid & ~is_neg & ~is_wrap;
      verdict.reject = valid & (is_neg | is_wrap);
   end
endmodule

// File: rtl/mono_sat_cnt.sv
module mono_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bump,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (bump && (q != TOP)) begin
         q <= q + 1'b1;
      end
   end
endmodule

// File: rtl/mono_guard.sv
module mono_guard #(
   parameter bit FORCE_LOCK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reject,
   input  logic lock_en,
   output logic locked,
   output logic flag,
   output logic tamper
);
   import mono_pkg::*;

   guard_state_e st_q;
   logic         want_lock;

   generate
      if (FORCE_LOCK) begin : g_always
         assign want_lock = 1'b1;
      end else begin : g_cfg
         assign want_lock = lock_en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= GS_RUN;
         flag   <= 1'b0;
         tamper <= 1'b0;
      end else begin
         unique case (st_q)
            GS_RUN: begin
               flag   <= reject;
               tamper <= reject;
               if (reject && want_lock) st_q <= GS_LOCKED;
            end
            GS_LOCKED: begin
               flag   <= 1'b0;
               tamper <= 1'b1;
            end
            default: st_q <= GS_LOCKED;
         endcase
      end
   end

   assign locked = (st_q == GS_LOCKED);
endmodule

// File: rtl/mono_counter.sv
module mono_counter #(
   parameter int CNT_W      = 64,
   parameter int INC_W      = 16,
   parameter int ANOM_W     = 8,
   parameter bit FORCE_LOCK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_valid,
   input  logic [INC_W-1:0]  inc_value,
   input  logic              lock_en,
   output logic [CNT_W-1:0]  count_o,
   output logic [ANOM_W-1:0] anomaly_cnt_o,
   output logic              anomaly_o,
   output logic              tamper_o,
   output logic              locked_o
);
   generate
      if (INC_W < 2 || INC_W > CNT_W) begin : g_bad_inc
         $error("mono_counter: INC_W must lie in 2..CNT_W");
      end
      if (ANOM_W < 1) begin : g_bad_anom
         $error("mono_counter: ANOM_W must be at least 1");
      end
   endgenerate

   mono_pkg::verdict_t vd;
   logic [CNT_W-1:0]   sum;
   logic [CNT_W-1:0]   cnt_q;
   logic               locked;
   logic               live_rej;
   logic               live_acc;

   mono_check #(.CNT_W(CNT_W), .INC_W(INC_W)) u_check (
      .cur     (cnt_q),
      .valid   (inc_valid),
      .inc     (inc_value),
      .verdict (vd),
      .nxt     (sum)
   );

   assign live_rej = vd.reject & ~locked;
   assign live_acc = vd.accept & ~locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (live_acc) begin
         cnt_q <= sum;
      end
   end

   mono_sat_cnt #(.W(ANOM_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (live_rej),
      .q     (anomaly_cnt_o)
   );

   mono_guard #(.FORCE_LOCK(FORCE_LOCK)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .reject  (live_rej),
      .lock_en (lock_en),
      .locked  (locked),
      .flag    (anomaly_o),
      .tamper  (tamper_o)
   );

   assign count_o  = cnt_q;
   assign locked_o = locked;
endmodule

// File: rtl/mono_counter_chk.sv
module mono_counter_chk #(
   parameter int CNT_W  = 64,
   parameter int INC_W  = 16,
   parameter int ANOM_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inc_valid,
   input logic [INC_W-1:0]  inc_value,
   input logic [CNT_W-1:0]  count_o,
   input logic [ANOM_W-1:0] anomaly_cnt_o,
   input logic              anomaly_o,
   input logic              tamper_o,
   input logic              locked_o
);
   localparam logic [ANOM_W-1:0] TOP = {ANOM_W{1'b1}};

   p_monotone_r12: assert property (@(posedge clk) disable iff (!rst_n)
      count_o >= $past(count_o));

   p_neg_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_valid && inc_value[INC_W-1]) |=> $stable(count_o));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_valid |=> $stable(count_o));

   p_tally_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (anomaly_cnt_o == TOP) |=> (anomaly_cnt_o == TOP));

   p_flag_tamper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      anomaly_o |-> tamper_o);

   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> (locked_o && tamper_o));

   p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> ($stable(count_o) && $stable(anomaly_cnt_o) && !anomaly_o));
endmodule

bind mono_counter mono_counter_chk #(
   .CNT_W(CNT_W), .INC_W(INC_W), .ANOM_W(ANOM_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inc_valid     (inc_valid),
   .inc_value     (inc_value),
   .count_o       (count_o),
   .anomaly_cnt_o (anomaly_cnt_o),
   .anomaly_o     (anomaly_o),
   .tamper_o      (tamper_o),
   .locked_o      (locked_o)
);

// File: tb/sim_mono_counter.sv
`timescale 1ns/1ps
module sim_mono_counter;
   localparam int TW = 20;
   localparam int TI = 16;
   localparam int TA = 3;
   localparam logic [TA-1:0] ATOP = {TA{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld = 1'b0;
   logic [TI-1:0] incv = '0;
   logic          lk = 1'b0;
   logic [TW-1:0] cnt;
   logic [TA-1:0] anom;
   logic          aflag, tamp, lockd;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [TW-1:0] m_count;
   logic [TA-1:0] m_anom;
   logic          m_locked, m_flag, m_tamp;

   always #10 clk = ~clk;

   mono_counter #(.CNT_W(TW), .INC_W(TI), .ANOM_W(TA)) u0 (
      .clk(clk), .rst_n(rst_n), .inc_valid(vld), .inc_value(incv),
      .lock_en(lk), .count_o(cnt), .anomaly_cnt_o(anom),
      .anomaly_o(aflag), .tamper_o(tamp), .locked_o(lockd)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " count"},  64'(cnt),   64'(m_count));
      chk({tag, " tally"},  64'(anom),  64'(m_anom));
      chk({tag, " flag"},   64'(aflag), 64'(m_flag));
      chk({tag, " tamper"}, 64'(tamp),  64'(m_tamp));
      chk({tag, " locked"}, 64'(lockd), 64'(m_locked));
   endtask

   // reference model: one clock of the update rules
   function automatic logic is_reject(input logic v, input logic [TI-1:0] inc,
                                      input logic [TW-1:0] cur);
      logic [TW:0] s;
      if (!v) return 1'b0;
      if (inc[TI-1]) return 1'b1;
      s = {1'b0, cur} + (TW+1)'(inc);
      return s[TW];
   endfunction

   task automatic cyc(input logic v, input logic [TI-1:0] inc, input logic le,
                      input string tag);
      logic rej;
      vld = v; incv = inc; lk = le;
      rej = is_reject(v, inc, m_count) && !m_locked;
      if (!m_locked) begin
         if (v && !rej) m_count = m_count + TW'(inc);
         if (rej && m_anom != ATOP) m_anom = m_anom + 1'b1;
         m_flag = rej;
         m_tamp = rej;
         if (rej && le) m_locked = 1'b1;
      end else begin
         m_flag = 1'b0;
         m_tamp = 1'b1;
      end
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; vld = 1'b0; incv = '0; lk = 1'b0;
      m_count = '0; m_anom = '0; m_locked = 1'b0; m_flag = 1'b0; m_tamp = 1'b0;
      repeat (2) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7411));
      @(negedge clk);
      do_reset();

      // directed basics, lock disabled
      cyc(1'b1, 16'd0,    1'b0, "R11 zero increment");
      cyc(1'b1, 16'd5,    1'b0, "R2 add five");
      cyc(1'b0, 16'd900,  1'b0, "R5 idle ignored");
      cyc(1'b1, 16'hFFFF, 1'b0, "R4 R6 R7 minus one rejected");
      cyc(1'b0, 16'd0,    1'b0, "R10 tamper drops");
      cyc(1'b1, 16'h7FFF, 1'b0, "R10 R2 accepts again");
      cyc(1'b1, 16'h8000, 1'b0, "R4 most negative rejected");

      // climb towards the top so sums wrap
      for (int i = 0; i < 40; i++) cyc(1'b1, 16'h7FFF, 1'b0, "R2 R3 climb");
      cyc(1'b1, 16'h7FFF, 1'b0, "R3 wrap rejected");

      // constrained random mix, lock disabled
      for (int i = 0; i < 400; i++) begin
         int sel;
         logic [TI-1:0] r;
         sel = int'($urandom_range(0, 9));
         if (sel < 3)      r = TI'($urandom_range(0, 16));
         else if (sel < 7) r = TI'($urandom_range(0, 32767));
         else if (sel < 8) r = TI'($urandom_range(32768, 65535));
         else              r = '0;
         cyc(sel != 9, r, 1'b0, "R2 R3 R4 R5 R6 random");
      end
      cyc(1'b1, 16'hFFF0, 1'b0, "R6 tally saturated");

      // lock path
      do_reset();
      cyc(1'b1, 16'd1234, 1'b1, "R2 before lock");
      cyc(1'b1, 16'hFFFE, 1'b1, "R8 negative locks");
      for (int i = 0; i < 20; i++)
         cyc(1'($urandom_range(0, 1)), TI'($urandom_range(0, 65535)),
             1'($urandom_range(0, 1)), "R8 R9 locked ignores");
      cyc(1'b1, 16'd1, 1'b0, "R9 small increment ignored");

      // reset is the only way out
      do_reset();
      cyc(1'b1, 16'd3, 1'b1, "R1 R2 counting after reset");

      finish_run();
   end
endmodule